// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compares

This block is the arithmetic and logic unit of a small load/store integer core. It is purely combinational. Each evaluation takes two operand words, a separate shift distance and a 4-bit operation code. It returns one result word and a flag that is high when that result is all zeros. The core's branch-on-equal path subtracts the two registers and looks at this flag.

The unit covers nine operations: add, subtract, AND, OR, NOR, signed less-than, unsigned less-than, left shift and right shift. Bitwise inversion has no opcode of its own. Software gets it as NOR against a zero operand. Subtracting a constant is done by adding its negative.

Inside, a small decoder turns the operation code into a packed set of strobes. A datapath uses those strobes to steer one shared adder, the logic gates, two log-depth shifters and the result merge. Neither arithmetic operation reports overflow: sums and differences wrap.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) gives opA + opB modulo 2^32. Adding 0xFFFFFFFF acts as subtracting 1. No overflow indication exists.
- R2: Code 1 (subtract) gives opA - opB modulo 2^32. Equal operands give 0.
- R3: Code 2 gives the bitwise AND of the operands. Code 3 gives the bitwise OR.
- R4: Code 4 gives ~(opA | opB). With opB = 0 the result is ~opA.
- R5: Code 5 compares the operands as two's-complement numbers, with bit 31 as the sign. The result is 1 when opA < opB and 0 otherwise. Bits 31..1 are always 0.
- R6: Code 6 compares the operands as unsigned numbers. The result is 1 when opA < opB and 0 otherwise. Bits 31..1 are always 0. With opA = 0xFFFFFFFF and opB = 1, code 6 gives 0 while code 5 gives 1.
- R7: Code 7 shifts opA left by shamt positions (0 to 31) and fills the vacated low bits with zeros. opB has no effect.
- R8: Code 8 shifts opA right by shamt positions (0 to 31) and fills the vacated high bits with zeros. opB has no effect.
- R9: Codes 9 through 15 give a result of 0.
- R10: zero is 1 exactly when the 32-bit result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand; the value that gets shifted |
| opB | input | 32 | Second operand |
| shamt | input | 5 | Shift distance for codes 7 and 8 |
| opSel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest cases to reach are those where the signed and unsigned compares disagree. These only occur when the operand sign bits differ, and every other operand pattern hides the difference. The vector table therefore applies the same opposite-sign pairs to both compare codes, including the most-negative against the most-positive value. It also includes pairs where the subtraction overflows, which exercises the sign-disagreement path of the signed compare. The shift tests hold opB at nonzero values while varying shamt, so that taking the distance from the wrong source would show up. They also sweep every shift distance for both directions.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_LTS  = 4'd5,
    OP_LTU  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8
  } aluOpE;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic selSum;
    logic selAnd;
    logic selOr;
    logic selNor;
    logic selLtS;
    logic selLtU;
    logic selShl;
    logic selShr;
  } aluStrobeT;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobeT  strobe
);

  always_comb begin
    strobe = '0;
    case (opSel)
      OP_ADD: strobe.selSum = 1'b1;
      OP_SUB: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
        strobe.selSum  = 1'b1;
      end
      OP_AND: strobe.selAnd = 1'b1;
      OP_OR:  strobe.selOr  = 1'b1;
      OP_NOR: strobe.selNor = 1'b1;
      OP_LTS: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
        strobe.selLtS  = 1'b1;
      end
      OP_LTU: begin
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
        strobe.selLtU  = 1'b1;
      end
      OP_SHL: strobe.selShl = 1'b1;
      OP_SHR: strobe.selShr = 1'b1;
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_dpath.sv
module int_alu_dpath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  aluStrobeT        strobe,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bMux;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH-1:0] sumWord;
  logic             carryOut;
  logic             lessSigned;
  logic             lessUnsigned;

  // One adder serves add, subtract and both compares
  assign bMux     = strobe.invertB ? ~opB : opB;
  assign sumFull  = {1'b0, opA} + {1'b0, bMux} + {{WIDTH{1'b0}}, strobe.carryIn};
  assign sumWord  = sumFull[MSB:0];
  assign carryOut = sumFull[WIDTH];

  // A - B borrows exactly when A < B unsigned
  assign lessUnsigned = ~carryOut;
  // Sign bits differ: the negative operand is smaller; else the difference sign decides
  assign lessSigned   = (opA[MSB] ^ opB[MSB]) ? opA[MSB] : sumWord[MSB];

  // Log-depth shifters, one stage per shift-distance bit
  logic [WIDTH-1:0] shlStage [SHW+1];
  logic [WIDTH-1:0] shrStage [SHW+1];

  assign shlStage[0] = opA;
  assign shrStage[0] = opA;

  for (genvar g = 0; g < SHW; g++) begin : gShiftStage
    assign shlStage[g+1] = shamt[g] ? (shlStage[g] << (1 << g)) : shlStage[g];
    assign shrStage[g+1] = shamt[g] ? (shrStage[g] >> (1 << g)) : shrStage[g];
  end

  // One-hot merge of the candidate results
  always_comb begin
    result = ({WIDTH{strobe.selSum}} & sumWord)
           | ({WIDTH{strobe.selAnd}} & (opA & opB))
           | ({WIDTH{strobe.selOr}}  & (opA | opB))
           | ({WIDTH{strobe.selNor}} & ~(opA | opB))
           | ({WIDTH{strobe.selShl}} & shlStage[SHW])
           | ({WIDTH{strobe.selShr}} & shrStage[SHW])
           | {{(WIDTH-1){1'b0}}, (strobe.selLtS & lessSigned) | (strobe.selLtU & lessUnsigned)};
  end

  assign zero = ~|result;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobeT strobe;

  int_alu_ctrl uCtrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  int_alu_dpath #(.WIDTH(WIDTH)) uDpath (
    .opA    (opA),
    .opB    (opB),
    .shamt  (shamt),
    .strobe (strobe),
    .result (result),
    .zero   (zero)
  );

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SHW-1:0]   shamt,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  always_comb begin
    if (opSel == OP_SUB && opA == opB)
      AST_SUB_EQUAL_ZERO: assert (result == '0) else $error("sub of equal operands nonzero"); // R2
    if (opSel == OP_NOR && opB == '0)
      AST_NOR_INVERTS: assert (result == ~opA) else $error("nor with zero is not inversion"); // R4
    if (opSel == OP_LTS)
      AST_LTS_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("signed compare upper bits set"); // R5
    if (opSel == OP_LTU)
      AST_LTU_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("unsigned compare upper bits set"); // R6
    if (opSel == OP_SHL && shamt != '0)
      AST_SHL_LOW_FILL: assert (result[0] == 1'b0) else $error("left shift did not fill zero"); // R7
    if (opSel == OP_SHR && shamt != '0)
      AST_SHR_HIGH_FILL: assert (result[WIDTH-1] == 1'b0) else $error("right shift did not fill zero"); // R8
    if (opSel > OP_SHR)
      AST_UNUSED_CODE: assert (result == '0) else $error("unused code gave nonzero"); // R9
    AST_ZERO_FLAG: assert (zero == (result == '0)) else $error("zero flag mismatch"); // R10
  end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) uChk (
  .opA    (opA),
  .opB    (opB),
  .shamt  (shamt),
  .opSel  (opSel),
  .result (result),
  .zero   (zero)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic        clk = 1'b0;
  logic [31:0] opA, opB, result;
  logic [4:0]  shamt;
  logic [3:0]  opSel;
  logic        zero;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu u0 (
    .opA(opA), .opB(opB), .shamt(shamt), .opSel(opSel),
    .result(result), .zero(zero)
  );

  // {opSel, opA, opB, shamt, expected}
  localparam logic [104:0] VEC [NVEC] = '{
    {4'd0, 32'h00000005, 32'h00000007, 5'd0,  32'h0000000C},
    {4'd0, 32'hFFFFFFFF, 32'h00000001, 5'd3,  32'h00000000},
    {4'd0, 32'h00000003, 32'hFFFFFFFF, 5'd0,  32'h00000002},
    {4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000},
    {4'd1, 32'h0000000A, 32'h00000003, 5'd0,  32'h00000007},
    {4'd1, 32'h00000000, 32'h00000001, 5'd0,  32'hFFFFFFFF},
    {4'd1, 32'h12345678, 32'h12345678, 5'd9,  32'h00000000},
    {4'd2, 32'h00000DC0, 32'h00003C00, 5'd0,  32'h00000C00},
    {4'd3, 32'h00000DC0, 32'h00003C00, 5'd0,  32'h00003DC0},
    {4'd4, 32'h00003C00, 32'h00000000, 5'd0,  32'hFFFFC3FF},
    {4'd4, 32'hF0F00000, 32'h0000F0F0, 5'd0,  32'h0F0F0F0F},
    {4'd5, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001},
    {4'd6, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000},
    {4'd5, 32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000000},
    {4'd6, 32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000001},
    {4'd5, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001},
    {4'd6, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000000},
    {4'd5, 32'h00000005, 32'h00000005, 5'd0,  32'h00000000},
    {4'd7, 32'h00000001, 32'h00000000, 5'd31, 32'h80000000},
    {4'd7, 32'hA5A5A5A5, 32'h0000001F, 5'd0,  32'hA5A5A5A5},
    {4'd8, 32'h80000000, 32'h00000002, 5'd31, 32'h00000001},
    {4'd8, 32'hFFFFFFFF, 32'h00000001, 5'd8,  32'h00FFFFFF},
    {4'd9, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd4,  32'h00000000},
    {4'd15, 32'h12345678, 32'h0000FFFF, 5'd1, 32'h00000000}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    @(posedge clk);
    opSel = op; opA = a; opB = b; shamt = sh;
    @(negedge clk);
  endtask

  initial begin
    opSel = 4'd0; opA = '0; opB = '0; shamt = '0;
    @(negedge clk);
    // Initial all-zero inputs: add of zeros
    check("R1", result, 32'h0);
    check("R10", {31'b0, zero}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][104:101], VEC[i][100:69], VEC[i][68:37], VEC[i][36:32]);
      check(reqOf(VEC[i][104:101]), result, VEC[i][31:0]);
      check("R10", {31'b0, zero}, {31'b0, VEC[i][31:0] == 32'h0});
    end

    // R7 / R8 sweep: every distance, opB held nonzero
    for (int s = 0; s < 32; s++) begin
      apply(4'd7, 32'h00000001, 32'hDEADBEEF, 5'(s));
      check("R7", result, 32'h1 << s);
      apply(4'd8, 32'h80000000, 32'hDEADBEEF, 5'(s));
      check("R8", result, 32'h80000000 >> s);
    end

    // R9: every unused code with operands that would give nonzero
    for (int c = 9; c < 16; c++) begin
      apply(4'(c), 32'hFFFF0000, 32'h0000FFFF, 5'd7);
      check("R9", result, 32'h0);
      check("R10", {31'b0, zero}, 32'h1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule